// File: doc/BRIEF.md
# Byte-Lane Sequencing Bridge

This block connects a 32-bit memory-mapped host port to an 8-bit external peripheral. That peripheral uses one chip select for both its data memory and its control registers, and some of those registers change state when they are read. For each host request, the bridge runs one narrow bus cycle for every byte lane whose byte enable is set. It leaves every other lane alone, and this applies to reads as well as writes. A plain width adapter would read all four bytes of every word and so trigger read side effects that software never asked for. This bridge does not.

The host keeps its request stable while the wait signal is high. The bridge handles the enabled lanes in turn, from lane 0 upward. Each lane gets its own strobe of configurable width, and one idle clock separates consecutive strobes. Read bytes are placed into their own lanes of the 32-bit result. Lanes that were not read return zero. Byte, halfword and word accesses all work, and so do word-by-word block copies, so the peripheral looks like ordinary memory.

Top module: `byte_lane_bridge`

## Requirements
- R1: After reset the bridge is idle: chip select, read strobe, write strobe and drive enable are low, wait is low while no request is present, and the read data is zero.
- R2: Enabled lanes are accessed in ascending lane order (bit 0 of the byte enable is lane 0, data bits 7:0). The peripheral address of each cycle is the host word address times 4 plus the lane index.
- R3: A read strobe is issued only for lanes whose byte enable is set, exactly once per enabled lane. A read of one enabled lane causes exactly one peripheral read.
- R4: A write produces one write cycle per enabled lane, carrying that lane's byte of the write data. A single-byte write causes exactly one peripheral write and leaves the other bytes of the word unchanged.
- R5: Wait is high from the cycle a request with at least one enable is presented. It drops exactly n*(STROBE_W+1) clocks later, where n is the number of enabled lanes.
- R6: Each strobe lasts STROBE_W clocks with chip select high. Chip select is low for at least one clock between strobes. Read and write strobes are never high together.
- R7: Read data is valid in the cycle in which wait drops, with each byte read placed in its own lane.
- R8: Byte lanes that were not read return zero in the read data.
- R9: A request with no byte enable set completes in the cycle it is presented (wait low), performs no peripheral access, and returns zero read data.
- R10: Consecutive word and byte requests copy a block of peripheral memory correctly, as they would on ordinary memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 6 | Host word address |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_be | input | 4 | Byte enables, bit i selects lane i |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Assembled read data |
| host_wait | output | 1 | Stall; high while the lane sequence runs |
| per_cs | output | 1 | Peripheral chip select |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | 8 | Peripheral byte address |
| per_dout | output | 8 | Peripheral write data |
| per_oe | output | 1 | Drive enable for the peripheral data bus |
| per_din | input | 8 | Peripheral read data |

## Verification
Requests are presented in cycle c. With n enabled lanes, wait is due to drop in cycle c + n*(STROBE_W+1), and the assembled read data is due in that same cycle. A request with no enables completes in cycle c itself. Each check waits for the falling edge in the middle of the cycle, counts the cycles until wait clears, compares the count with that formula, and samples the read data in that cycle only. A monitor also samples the peripheral pins at falling edges. It logs each strobe's address, direction and data, and measures strobe widths and chip-select gaps against STROBE_W.

// File: rtl/byte_lane_bridge_pkg.sv
package byte_lane_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/blb_lane_pick.sv
module blb_lane_pick #(
  parameter int LANES  = 4,
  parameter int LIDX_W = 2
) (
  input  logic [LANES-1:0]  mask,
  output logic [LIDX_W-1:0] lane,
  output logic              any
);
  always_comb begin
    lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) lane = LIDX_W'(i);
    end
    any = |mask;
  end
endmodule

// File: rtl/blb_strobe_timer.sv
module blb_strobe_timer #(
  parameter int STROBE_W = 2,
  parameter int CNT_W    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= CNT_W'(STROBE_W - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/blb_rdata_asm.sv
module blb_rdata_asm #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int LIDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    cap,
  input  logic [LIDX_W-1:0]       cap_lane,
  input  logic [BYTE_W-1:0]       din,
  output logic [LANES*BYTE_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clear) byte_q <= '0;
      else if (cap && cap_lane == LIDX_W'(g)) byte_q <= din;
    end
    assign rdata[g*BYTE_W +: BYTE_W] = byte_q;
  end

  // R8: after a clear the result is all zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (rdata == '0));
endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge
  import byte_lane_bridge_pkg::*;
#(
  parameter int HOST_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int PADDR_W  = 8,
  parameter int STROBE_W = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [PADDR_W-$clog2(HOST_W/BYTE_W)-1:0] host_addr,
  input  logic                              host_rd,
  input  logic                              host_wr,
  input  logic [HOST_W/BYTE_W-1:0]          host_be,
  input  logic [HOST_W-1:0]                 host_wdata,
  output logic [HOST_W-1:0]                 host_rdata,
  output logic                              host_wait,
  output logic                              per_cs,
  output logic                              per_rd,
  output logic                              per_wr,
  output logic [PADDR_W-1:0]                per_addr,
  output logic [BYTE_W-1:0]                 per_dout,
  output logic                              per_oe,
  input  logic [BYTE_W-1:0]                 per_din
);
  localparam int LANES   = HOST_W / BYTE_W;
  localparam int LIDX_W  = $clog2(LANES);
  localparam int WADDR_W = PADDR_W - LIDX_W;
  localparam int CNT_W   = $clog2(STROBE_W + 1);

  seq_state_t          state;
  logic [LANES-1:0]    pending, be_q, cur_mask, pend_next, pick_in;
  logic [WADDR_W-1:0]  waddr_q;
  logic [HOST_W-1:0]   wdata_q;
  logic                isrd_q;
  logic [LIDX_W-1:0]   cur_lane, pick_lane;
  logic                pick_any, req, start_req, load, t_last, strobe_end;

  assign req       = host_rd | host_wr;
  assign start_req = (state == ST_IDLE) && req && (|host_be);
  assign cur_mask  = LANES'(1) << cur_lane;
  assign pend_next = pending & ~cur_mask;
  assign pick_in   = (state == ST_IDLE) ? host_be : pend_next;
  assign load      = start_req || (state == ST_GAP);
  assign strobe_end = (state == ST_STROBE) && t_last;

  blb_lane_pick #(.LANES(LANES), .LIDX_W(LIDX_W)) u_pick (
    .mask(pick_in), .lane(pick_lane), .any(pick_any)
  );

  blb_strobe_timer #(.STROBE_W(STROBE_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .last(t_last)
  );

  blb_rdata_asm #(.LANES(LANES), .BYTE_W(BYTE_W), .LIDX_W(LIDX_W)) u_asm (
    .clk(clk), .rst(rst),
    .clear(start_req || (state == ST_DONE)),
    .cap(strobe_end && isrd_q), .cap_lane(cur_lane), .din(per_din),
    .rdata(host_rdata)
  );

  always_comb begin
    host_wait = 1'b0;
    if (req) begin
      case (state)
        ST_IDLE:   host_wait = |host_be;
        ST_STROBE: host_wait = 1'b1;
        ST_GAP:    host_wait = 1'b1;
        default:   host_wait = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pending  <= '0;
      be_q     <= '0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      isrd_q   <= 1'b0;
      cur_lane <= '0;
      per_cs   <= 1'b0;
      per_rd   <= 1'b0;
      per_wr   <= 1'b0;
      per_oe   <= 1'b0;
      per_addr <= '0;
      per_dout <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            pending  <= host_be;
            be_q     <= host_be;
            waddr_q  <= host_addr;
            wdata_q  <= host_wdata;
            isrd_q   <= host_rd;
            cur_lane <= pick_lane;
            per_cs   <= 1'b1;
            per_rd   <= host_rd;
            per_wr   <= ~host_rd;
            per_oe   <= ~host_rd;
            per_addr <= {host_addr, pick_lane};
            per_dout <= host_wdata[pick_lane*BYTE_W +: BYTE_W];
            state    <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (t_last) begin
            per_cs  <= 1'b0;
            per_rd  <= 1'b0;
            per_wr  <= 1'b0;
            per_oe  <= 1'b0;
            pending <= pend_next;
            state   <= pick_any ? ST_GAP : ST_DONE;
          end
        end
        ST_GAP: begin
          cur_lane <= pick_lane;
          per_cs   <= 1'b1;
          per_rd   <= isrd_q;
          per_wr   <= ~isrd_q;
          per_oe   <= ~isrd_q;
          per_addr <= {waddr_q, pick_lane};
          per_dout <= wdata_q[pick_lane*BYTE_W +: BYTE_W];
          state    <= ST_STROBE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a read strobe only reaches a lane the host enabled
  p_rd_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    per_rd |-> (be_q[per_addr[LIDX_W-1:0]] && isrd_q));

  // R2: every cycle addresses the captured host word
  p_addr_word_r2: assert property (@(posedge clk) disable iff (rst)
    per_cs |-> (per_addr[PADDR_W-1:LIDX_W] == waddr_q));

  // R6: chip select drops together with each strobe
  p_gap_cs_low_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(per_rd || per_wr) |-> !per_cs);

  // R6: the two strobes are exclusive
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(per_rd && per_wr));

  // R5: host stays stalled while a peripheral cycle runs
  p_wait_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (per_cs && req) |-> host_wait);

  // R9: empty enable mask starts no cycle
  p_empty_noacc_r9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && req && (host_be == '0)) |=> !per_cs);

  if (STROBE_W > 1) begin : g_hold_chk
    // R6: a strobe is held beyond its first clock
    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(per_rd || per_wr) |=> (per_rd || per_wr));
  end
endmodule

// File: tb/byte_lane_bridge_bench.sv
module byte_lane_bridge_bench;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_wait, per_cs, per_rd, per_wr, per_oe;
  logic [7:0]  per_addr, per_dout, per_din;

  byte_lane_bridge #(.STROBE_W(W)) u_byte_lane_bridge (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_wait(host_wait), .per_cs(per_cs),
    .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr),
    .per_dout(per_dout), .per_oe(per_oe), .per_din(per_din)
  );

  always #5 clk = ~clk;

  logic [7:0] mem [256];
  assign per_din = per_rd ? mem[per_addr] : 8'h00;

  int checks = 0, fails = 0;
  int ev_n = 0;
  logic [7:0] ev_addr [8];
  logic       ev_rd   [8];
  logic [7:0] ev_data [8];
  int hcnt = 0, width_err = 0, cs_err = 0, excl_err = 0;
  logic prev_strobe = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if ((per_rd || per_wr) && !prev_strobe) begin
        if (ev_n < 8) begin
          ev_addr[ev_n] = per_addr;
          ev_rd[ev_n]   = per_rd;
          ev_data[ev_n] = per_dout;
        end
        ev_n = ev_n + 1;
        if (per_wr) mem[per_addr] = per_dout;
      end
      if (per_rd || per_wr) hcnt = hcnt + 1;
      else if (prev_strobe) begin
        if (hcnt != W) width_err = width_err + 1;
        hcnt = 0;
      end
      if (per_cs != (per_rd || per_wr)) cs_err = cs_err + 1;
      if (per_rd && per_wr) excl_err = excl_err + 1;
      prev_strobe = per_rd || per_wr;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd = wd + 1;
    if (wd == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog R5: actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [5:0] addr, input logic [3:0] be,
                        input logic [31:0] wd_in, output logic [31:0] rdata, output int cyc);
    @(negedge clk);
    ev_n = 0;
    host_addr = addr; host_be = be; host_wdata = wd_in;
    host_rd = rd; host_wr = ~rd;
    #1;
    cyc = 0;
    while (host_wait) begin
      @(negedge clk);
      cyc = cyc + 1;
    end
    rdata = host_rdata;
    @(posedge clk);
    #1;
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  // checks lane order (R2), lane selection (R3/R4), timing (R5) and read data (R7/R8)
  task automatic run_and_check(input string name, input logic rd, input logic [5:0] addr,
                               input logic [3:0] be, input logic [31:0] wd_in);
    logic [31:0] exp_rd, got;
    logic [7:0]  snap [4];
    int cyc, n, k;
    n = 0; exp_rd = '0;
    for (int l = 0; l < 4; l++) begin
      snap[l] = mem[{addr, 2'(l)}];
      if (be[l]) begin
        n++;
        exp_rd[l*8 +: 8] = snap[l];
      end
    end
    access(rd, addr, be, wd_in, got, cyc);
    chk({name, " R5 cycles"}, 32'(cyc), 32'(n * (W + 1)));
    chk({name, " R3 access count"}, 32'(ev_n), 32'(n));
    k = 0;
    for (int l = 0; l < 4; l++) begin
      if (be[l] && k < 8) begin
        chk({name, " R2 address"}, 32'(ev_addr[k]), 32'({addr, 2'(l)}));
        chk({name, " R3 direction"}, 32'(ev_rd[k]), 32'(rd));
        if (!rd) chk({name, " R4 write byte"}, 32'(ev_data[k]), 32'(wd_in[l*8 +: 8]));
        k++;
      end
    end
    if (rd) chk({name, " R7 R8 rdata"}, got, exp_rd);
  endtask

  task automatic t_reset();
    chk("R1 cs", 32'(per_cs), 0);
    chk("R1 strobes", 32'({per_rd, per_wr, per_oe}), 0);
    chk("R1 wait", 32'(host_wait), 0);
    chk("R1 rdata", host_rdata, 0);
  endtask

  task automatic t_reads();
    run_and_check("word read", 1'b1, 6'd3, 4'b1111, '0);
    run_and_check("single lane read", 1'b1, 6'd5, 4'b0100, '0);
    run_and_check("sparse read", 1'b1, 6'd9, 4'b1001, '0);
    run_and_check("high half read", 1'b1, 6'd10, 4'b1100, '0);
  endtask

  task automatic t_writes();
    logic [31:0] got;
    int cyc;
    run_and_check("byte write", 1'b0, 6'd7, 4'b0010, 32'hAABBCCDD);
    access(1'b1, 6'd7, 4'b1111, '0, got, cyc);
    chk("R4 byte write readback", got,
        {8'(7*4+3)*8'd7 + 8'd3, 8'(7*4+2)*8'd7 + 8'd3, 8'hCC, 8'(7*4)*8'd7 + 8'd3});
    run_and_check("half write", 1'b0, 6'd8, 4'b1100, 32'h12345678);
    access(1'b1, 6'd8, 4'b1111, '0, got, cyc);
    chk("R4 half write readback", got[31:16], 32'h1234);
  endtask

  task automatic t_empty();
    logic [31:0] got;
    int cyc;
    access(1'b1, 6'd2, 4'b0000, '0, got, cyc);
    chk("R9 read cycles", 32'(cyc), 0);
    chk("R9 read access", 32'(ev_n), 0);
    chk("R9 rdata", got, 0);
    access(1'b0, 6'd2, 4'b0000, 32'hFFFFFFFF, got, cyc);
    chk("R9 write cycles", 32'(cyc), 0);
    chk("R9 write access", 32'(ev_n), 0);
  endtask

  task automatic t_copy();
    logic [31:0] src [5], got, b;
    int cyc;
    for (int w = 0; w < 4; w++) begin
      access(1'b1, 6'(w), 4'b1111, '0, src[w], cyc);
      access(1'b0, 6'(40 + w), 4'b1111, src[w], got, cyc);
    end
    src[4] = '0;
    for (int l = 0; l < 4; l++) begin
      access(1'b1, 6'd4, 4'(1 << l), '0, b, cyc);
      src[4] = src[4] | b;
      access(1'b0, 6'd44, 4'(1 << l), b, got, cyc);
    end
    for (int w = 0; w < 5; w++) begin
      logic [31:0] e;
      for (int l = 0; l < 4; l++) e[l*8 +: 8] = 8'((w*4 + l) * 7 + 3);
      chk("R10 source word", src[w], e);
      access(1'b1, 6'(40 + w), 4'b1111, '0, got, cyc);
      chk("R10 copied word", got, e);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_copy();
    t_reads();
    t_writes();
    t_empty();
    repeat (3) @(negedge clk);
    chk("R6 strobe width", 32'(width_err), 0);
    chk("R6 cs gap", 32'(cs_err), 0);
    chk("R6 exclusive strobes", 32'(excl_err), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule